// File: doc/BRIEF.md
# Tag-Only Set-Associative Hit/Miss Tracker

This block models the lookup side of a set-associative cache without holding any data. For every way of every set it keeps only a stored tag and a valid flag. Each accepted request carries a byte address. The block cuts the address into three fields: the offset inside a block, the set number and the tag. It compares the tag against every way of the selected set and reports one cycle later whether the access hit, together with the way that holds the line. On a miss, the line is installed at once, so the following access already sees it.

When a set still has an empty way, a miss always lands in the lowest-numbered empty way. Once the set is full, a replacement policy picks the victim. The policy is chosen per access from three options. Least-recently-used uses a per-set generation counter that stamps each way on every touch. First-in-first-out uses a per-set rotation pointer. Random uses a free-running LFSR. Block size, associativity and set count are power-of-two parameters. Typical uses are miss-rate profiling and tracking the tags of a larger cache.

Top module: `cache_tag_engine`

## Requirements
- R1: The lowest log2(BLK_BYTES) address bits are the block offset and have no effect on the result. The next log2(SETS) bits select the set. All remaining upper bits form the tag.
- R2: An access hits only when a way of its own set is valid and holds an equal tag. The reported way is that way's index. A matching tag held in another set does not count.
- R3: On a miss in a set that has an empty way, the lowest-numbered empty way receives the tag and becomes valid, whatever policy is selected.
- R4: `req_ready` is always high and one request is taken per cycle. `rsp_valid` is high exactly in the cycle after an accepted request, and `rsp_hit`/`rsp_way` belong to that request. A line installed by a miss hits on the very next accepted request.
- R5: Synchronous reset empties every way and clears counters, pointers and the response. After reset `rsp_valid` is low, and the first access misses into way 0.
- R6: `policy_sel` = 0 (or 3) selects least-recently-used. Every hit and every fill, under any policy, stamps the touched way with its set's generation count, and the count then increments. The victim is the way with the smallest stamp, with ties going to the lower index.
- R7: `policy_sel` = 1 selects first-in-first-out. Within a set, victims rotate through ways 0, 1, …, WAYS-1, and the rotation pointer advances only when a full-set miss is taken under this policy. Hits do not move it.
- R8: `policy_sel` = 2 selects random. The victim index is the low log2(WAYS) bits of a free-running LFSR, and only that way loses its line.
- R9: The policy is sampled with each request, so switching it between accesses acts immediately, using the stamps and pointers accumulated up to then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken (always high) |
| req_addr | input | ADDR_W | Byte address of the access |
| policy_sel | input | 2 | Replacement policy: 0 LRU, 1 FIFO, 2 random, 3 LRU |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_hit | output | 1 | 1 = hit, 0 = miss (line now installed) |
| rsp_way | output | log2(WAYS) | Way that hit or was filled |

## Verification
The bench builds the block with its defaults: 16-bit addresses, 16-byte blocks, 4 ways and 8 sets, which gives a 9-bit tag. Four ways are enough to fill a set and then take several distinct conflict misses in a few accesses. Under these values the LRU ordering, the FIFO rotation and a policy switch all lead to different victims, so each policy's choice can be told apart. Eight sets let the bench show that the same tag in another set, and a change in the offset bits, are handled correctly.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    typedef enum logic [1:0] {
        EVICT_LRU  = 2'd0,
        EVICT_FIFO = 2'd1,
        EVICT_RAND = 2'd2,
        EVICT_ALT  = 2'd3
    } evict_e;

endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr #(
    parameter int          W     = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] state
);
    logic [W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {1'b0, lfsr_q[W-1:1]};
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) lfsr_q <= SEED[W-1:0];
        else     lfsr_q <= lfsr_d;
    end

    assign state = lfsr_q;
endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 9,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid_row,
    input  logic [WAYS-1:0][TAG_W-1:0] tag_row,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_row[w] && (tag_row[w] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick
    import cache_tag_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int GEN_W = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid_row,
    input  logic [WAYS-1:0][GEN_W-1:0] stamp_row,
    input  logic [WAY_W-1:0]           fifo_ptr,
    input  logic [WAY_W-1:0]           rnd,
    input  evict_e                     policy,
    output logic                       conflict,
    output logic [WAY_W-1:0]           victim
);
    logic [WAY_W-1:0] empty_way;
    logic [WAY_W-1:0] oldest_way;

    // lowest empty way wins
    always_comb begin
        empty_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_row[w]) empty_way = WAY_W'(w);
        end
    end

    // strict less-than keeps the lower index on equal stamps
    always_comb begin
        oldest_way = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (stamp_row[w] < stamp_row[oldest_way]) oldest_way = WAY_W'(w);
        end
    end

    assign conflict = &valid_row;

    always_comb begin
        if (!conflict) begin
            victim = empty_way;
        end else begin
            case (policy)
                EVICT_FIFO: victim = fifo_ptr;
                EVICT_RAND: victim = rnd;
                default:    victim = oldest_way;
            endcase
        end
    end
endmodule

// File: rtl/cache_tag_engine.sv
module cache_tag_engine
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 16,
    parameter int WAYS      = 4,
    parameter int SETS      = 8,
    parameter int GEN_W     = 32,
    parameter int LFSR_W    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               policy_sel,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [$clog2(WAYS)-1:0]  rsp_way
);
    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tags;
        logic [SETS-1:0][WAYS-1:0][GEN_W-1:0]  stamps;
        logic [SETS-1:0][GEN_W-1:0]            gen;
        logic [SETS-1:0][WAY_W-1:0]            fptr;
        logic                                  rsp_valid;
        logic                                  rsp_hit;
        logic [WAY_W-1:0]                      rsp_way;
    } state_t;

    state_t st_d, st_q;

    logic              accept;
    logic [IDX_W-1:0]  set_idx;
    logic [TAG_W-1:0]  tag;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic              conflict;
    logic [WAY_W-1:0]  victim;
    logic [LFSR_W-1:0] lfsr;
    evict_e            policy;
    logic              unused_bits;

    assign req_ready   = 1'b1;
    assign accept      = req_valid && req_ready;
    assign set_idx     = req_addr[OFF_W +: IDX_W];
    assign tag         = req_addr[ADDR_W-1 -: TAG_W];
    assign policy      = evict_e'(policy_sel);
    assign unused_bits = ^{req_addr[OFF_W-1:0], lfsr[LFSR_W-1:WAY_W]};

    cache_lfsr #(.W(LFSR_W)) i_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (lfsr)
    );

    cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
        .valid_row (st_q.valid[set_idx]),
        .tag_row   (st_q.tags[set_idx]),
        .tag       (tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    cache_victim_pick #(.WAYS(WAYS), .GEN_W(GEN_W)) i_victim (
        .valid_row (st_q.valid[set_idx]),
        .stamp_row (st_q.stamps[set_idx]),
        .fifo_ptr  (st_q.fptr[set_idx]),
        .rnd       (lfsr[WAY_W-1:0]),
        .policy    (policy),
        .conflict  (conflict),
        .victim    (victim)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = accept;
        st_d.rsp_hit   = 1'b0;
        st_d.rsp_way   = '0;
        if (accept) begin
            if (hit) begin
                st_d.rsp_hit                  = 1'b1;
                st_d.rsp_way                  = hit_way;
                st_d.stamps[set_idx][hit_way] = st_q.gen[set_idx];
            end else begin
                st_d.rsp_way                 = victim;
                st_d.valid[set_idx][victim]  = 1'b1;
                st_d.tags[set_idx][victim]   = tag;
                st_d.stamps[set_idx][victim] = st_q.gen[set_idx];
                if (conflict && policy == EVICT_FIFO)
                    st_d.fptr[set_idx] = st_q.fptr[set_idx] + WAY_W'(1);
            end
            st_d.gen[set_idx] = st_q.gen[set_idx] + GEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_way   = st_q.rsp_way;
endmodule

// File: rtl/cache_tag_engine_chk.sv
module cache_tag_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int WAY_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [WAY_W-1:0]  rsp_way
);
    logic              acc;
    logic              prev_acc_q;
    logic [ADDR_W-1:0] prev_addr_q;
    logic              first_q;
    logic              unused_off;

    assign acc        = req_valid && req_ready;
    assign unused_off = ^req_addr[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_acc_q  <= 1'b0;
            prev_addr_q <= '0;
            first_q     <= 1'b1;
        end else begin
            prev_acc_q  <= acc;
            prev_addr_q <= req_addr;
            if (rsp_valid) first_q <= 1'b0;
        end
    end

    // R4
    rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);

    // R4
    no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid);

    // R4
    repeat_line_hits_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && prev_acc_q && req_addr[ADDR_W-1:OFF_W] == prev_addr_q[ADDR_W-1:OFF_W])
        |=> (rsp_hit && rsp_way == $past(rsp_way)));

    // R5
    first_access_misses_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && first_q) |-> (!rsp_hit && rsp_way == '0));
endmodule

bind cache_tag_engine cache_tag_engine_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .WAY_W  (WAY_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way)
);

// File: tb/test_cache_tag_engine.sv
`timescale 1ns/1ps
module test_cache_tag_engine;
    localparam int ADDR_W = 16;
    localparam int WAY_W  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        policy_sel = 2'd0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [WAY_W-1:0]  rsp_way;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    cache_tag_engine i_cache_tag_engine (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .policy_sel (policy_sel),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_way    (rsp_way)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    function automatic logic [ADDR_W-1:0] mk(int t, int s, int off);
        return ADDR_W'((t << 7) | (s << 4) | off);
    endfunction

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one access; response sampled at the negedge after the accepting edge
    task automatic access(logic [ADDR_W-1:0] a, output logic hit, output logic [WAY_W-1:0] way);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        hit = rsp_hit; way = rsp_way;
        check("R4 rsp_valid after accept", int'(rsp_valid), 1);
    endtask

    task automatic expect_acc(string req, logic [ADDR_W-1:0] a, logic eh, int ew);
        logic h; logic [WAY_W-1:0] w;
        access(a, h, w);
        check({req, " hit"}, int'(h), int'(eh));
        check({req, " way"}, int'(w), ew);
    endtask

    task automatic fill_set0();
        for (int t = 1; t <= 4; t++) expect_acc("R3 compulsory fill", mk(t, 0, 0), 1'b0, t - 1);
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check("R5 rsp_valid low after reset", int'(rsp_valid), 0);
        check("R4 ready high", int'(req_ready), 1);
        expect_acc("R5 first access", mk(7, 2, 0), 1'b0, 0);
        @(negedge clk);
        check("R4 no rsp when idle", int'(rsp_valid), 0);
    endtask

    task automatic t_fill_and_hit();
        do_reset();
        policy_sel = 2'd0;
        fill_set0();
        for (int t = 1; t <= 4; t++) expect_acc("R2 hit", mk(t, 0, 0), 1'b1, t - 1);
        expect_acc("R1 offset ignored", mk(2, 0, 15), 1'b1, 1);
        expect_acc("R2 other set misses", mk(1, 5, 0), 1'b0, 0);
        expect_acc("R1 set field selects", mk(1, 5, 3), 1'b1, 0);
    endtask

    task automatic t_back_to_back();
        do_reset();
        @(negedge clk);
        req_valid = 1'b1; req_addr = mk(9, 1, 0);
        @(negedge clk);
        check("R4 b2b first miss", int'(rsp_hit), 0);
        check("R4 b2b first way", int'(rsp_way), 0);
        req_addr = mk(9, 1, 4);
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 b2b fill visible", int'(rsp_hit), 1);
        check("R4 b2b valid", int'(rsp_valid), 1);
    endtask

    task automatic t_lru();
        do_reset();
        policy_sel = 2'd0;
        fill_set0();
        expect_acc("R6 touch", mk(1, 0, 0), 1'b1, 0);
        expect_acc("R6 victim oldest", mk(5, 0, 0), 1'b0, 1);
        expect_acc("R6 next oldest", mk(2, 0, 0), 1'b0, 2);
        expect_acc("R6 new line kept", mk(5, 0, 0), 1'b1, 1);
        policy_sel = 2'd3;
        expect_acc("R6 code 3 is LRU", mk(6, 0, 0), 1'b0, 3);
    endtask

    task automatic t_fifo();
        do_reset();
        policy_sel = 2'd1;
        fill_set0();
        expect_acc("R7 hit no effect", mk(1, 0, 0), 1'b1, 0);
        expect_acc("R7 first victim", mk(5, 0, 0), 1'b0, 0);
        expect_acc("R7 second victim", mk(6, 0, 0), 1'b0, 1);
        expect_acc("R7 third victim", mk(1, 0, 0), 1'b0, 2);
        expect_acc("R7 replaced line present", mk(5, 0, 0), 1'b1, 0);
        expect_acc("R7 other set own pointer", mk(3, 4, 0), 1'b0, 0);
    endtask

    task automatic t_switch();
        do_reset();
        policy_sel = 2'd1;
        fill_set0();
        expect_acc("R9 hit under fifo", mk(1, 0, 0), 1'b1, 0);
        expect_acc("R9 hit under fifo", mk(2, 0, 0), 1'b1, 1);
        policy_sel = 2'd0;
        expect_acc("R9 lru uses stamps from fifo phase", mk(5, 0, 0), 1'b0, 2);
    endtask

    task automatic t_random();
        logic h; logic [WAY_W-1:0] w;
        do_reset();
        policy_sel = 2'd2;
        fill_set0();
        access(mk(9, 0, 0), h, w);
        check("R8 conflict miss", int'(h), 0);
        for (int t = 1; t <= 4; t++) begin
            if (t - 1 != int'(w)) expect_acc("R8 survivor", mk(t, 0, 0), 1'b1, t - 1);
        end
        expect_acc("R8 new line at victim", mk(9, 0, 0), 1'b1, int'(w));
        access(mk(int'(w) + 1, 0, 0), h, w);
        check("R8 evicted line gone", int'(h), 0);
    endtask

    initial begin
        t_reset_state();
        t_fill_and_hit();
        t_back_to_back();
        t_lru();
        t_fifo();
        t_switch();
        t_random();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule